// File: doc/BRIEF.md
# Ciphertext Unpack and Decompress Engine

This block turns a packed lattice-KEM ciphertext into polynomial coefficients. The ciphertext sits in a byte-addressed memory, starting at address 0, as one contiguous byte stream. After a start pulse the engine reads the bytes in increasing order and feeds them into a bit accumulator, least significant bit first. It cuts the accumulated bits into fixed-width symbols and expands each symbol to a coefficient modulo 3329 through a two-stage decompressor. Every coefficient appears on a write port together with its polynomial and coefficient indices.

The stream holds K polynomials packed at width du, followed at once by a single polynomial packed at width dv. Coefficients of the first group go out through write strobe A. The final polynomial goes out through write strobe B. A one-cycle done pulse marks the end of the job. Downstream transforms and arithmetic are outside this block.

Top module: `ct_unpack`

## Requirements
- R1: While reset is held and immediately after it, done, we_a and we_b are 0 and mem_addr is 0.
- R2: Byte b of the stream holds stream bits 8b..8b+7, with byte bit 0 first. Each symbol takes the next d unread stream bits, the earliest bit as symbol bit 0.
- R3: Each written coefficient equals floor((3329*y + 2^(d-1)) / 2^d) for its symbol y and width d, and is always below 3329.
- R4: The first K*256 writes use d = du and assert we_a only. Their poly_idx runs 0..K-1 and their coef_idx runs 0..255 in order within each polynomial. we_a and we_b are never high together.
- R5: The next 256 writes use d = dv and assert we_b only, with poly_idx 0. Their symbols start at the stream bit right after the last du symbol.
- R6: Memory reads have one cycle of latency: the byte at the address shown on mem_addr is taken from mem_data in the following cycle. mem_addr starts at 0 for each job and never rises by more than 1 per cycle. In the cycle after the last write it equals the number of bytes consumed, (K*256*du + 256*dv)/8.
- R7: done is high for exactly one cycle, the cycle after the write of coefficient 255 of the dv polynomial, and at no other time.
- R8: While a job runs, start and changes on k_in, du_in and dv_in have no effect on that job's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a job when idle |
| k_in | input | 3 | Number of du polynomials, 2 to 4 |
| du_in | input | 4 | Symbol width of the first group, 1 to 12 |
| dv_in | input | 4 | Symbol width of the final polynomial, 1 to 12 |
| mem_addr | output | 11 | Byte read address |
| mem_data | input | 8 | Byte read data, one cycle after the address |
| coef_out | output | 12 | Decompressed coefficient |
| poly_idx | output | 3 | Polynomial index of the current write |
| coef_idx | output | 8 | Coefficient index of the current write |
| we_a | output | 1 | Write strobe for du polynomials |
| we_b | output | 1 | Write strobe for the dv polynomial |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
The hardest case to reach is the switch from du to dv. Bits left in the accumulator after the last du symbol must become the low bits of the first dv symbol, and the accumulator may then hold enough bits to skip a fetch. The stimulus varies the two widths widely, from wide du with narrow dv to narrow du with wide dv. This puts the accumulator fill level at the switch in different states. Every coefficient is compared with a model that rebuilds the bit stream on its own from the same memory image. A start pulse with different parameters is injected in the middle of one job to show that the job runs unchanged.

// File: rtl/ct_unpack.sv
module ct_unpack #(
  parameter int Q  = 3329,
  parameter int N  = 256,
  parameter int CW = 12,
  parameter int AW = 11,
  parameter int DW = 4,
  parameter int KW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [KW-1:0] k_in,
  input  logic [DW-1:0] du_in,
  input  logic [DW-1:0] dv_in,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_data,
  output logic [CW-1:0] coef_out,
  output logic [KW-1:0] poly_idx,
  output logic [$clog2(N)-1:0] coef_idx,
  output logic          we_a,
  output logic          we_b,
  output logic          done
);
  localparam int BW  = CW + 8;
  localparam int NBW = $clog2(BW + 1);
  localparam int IW  = $clog2(N);
  localparam int QW  = $clog2(Q);
  localparam int PW  = QW + CW;

  logic          busy;
  logic [1:0]    ph;
  logic [KW-1:0] k_q, fpoly, pidx;
  logic [DW-1:0] du_q, dv_q, dq;
  logic [BW-1:0] buf_q;
  logic [NBW-1:0] nb;
  logic [AW-1:0] ptr;
  logic [IW-1:0] fidx, widx;
  logic [CW-1:0] sym_q, res_q;

  wire [DW-1:0] d_cur = (fpoly == k_q) ? dv_q : du_q;
  wire          have  = nb >= NBW'(d_cur);
  wire [BW-1:0] mask  = (BW'(1) << d_cur) - BW'(1);
  wire [CW-1:0] sym   = CW'(buf_q & mask);
  wire [PW-1:0] prod  = PW'(Q) * PW'(sym_q) + (PW'(1) << (dq - DW'(1)));
  wire          last_poly = (pidx == k_q);

  assign mem_addr = ptr;
  assign coef_out = res_q;
  assign coef_idx = widx;
  assign poly_idx = last_poly ? '0 : pidx;
  assign we_a     = busy && (ph == 2'd3) && !last_poly;
  assign we_b     = busy && (ph == 2'd3) && last_poly;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      ph    <= 2'd0;
      k_q   <= '0;
      du_q  <= '0;
      dv_q  <= '0;
      dq    <= '0;
      buf_q <= '0;
      nb    <= '0;
      ptr   <= '0;
      fidx  <= '0;
      widx  <= '0;
      fpoly <= '0;
      pidx  <= '0;
      sym_q <= '0;
      res_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          k_q   <= k_in;
          du_q  <= du_in;
          dv_q  <= dv_in;
          ph    <= 2'd0;
          buf_q <= '0;
          nb    <= '0;
          ptr   <= '0;
          fidx  <= '0;
          widx  <= '0;
          fpoly <= '0;
          pidx  <= '0;
        end
      end else begin
        case (ph)
          2'd0: begin
            if (have) begin
              sym_q <= sym;
              dq    <= d_cur;
              buf_q <= buf_q >> d_cur;
              nb    <= nb - NBW'(d_cur);
              fidx  <= fidx + IW'(1);
              if (fidx == IW'(N - 1)) fpoly <= fpoly + KW'(1);
              ph    <= 2'd2;
            end else begin
              ph <= 2'd1;
            end
          end
          2'd1: begin
            buf_q <= buf_q | (BW'(mem_data) << nb);
            nb    <= nb + NBW'(8);
            ptr   <= ptr + AW'(1);
            ph    <= 2'd0;
          end
          2'd2: begin
            res_q <= CW'(prod >> dq);
            ph    <= 2'd3;
          end
          default: begin
            widx <= widx + IW'(1);
            if (widx == IW'(N - 1)) begin
              if (last_poly) begin
                busy <= 1'b0;
                done <= 1'b1;
              end else begin
                pidx <= pidx + KW'(1);
              end
            end
            ph <= 2'd0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/ct_unpack_chk.sv
module ct_unpack_chk #(
  parameter int Q  = 3329,
  parameter int CW = 12,
  parameter int AW = 11,
  parameter int IW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          we_a,
  input logic          we_b,
  input logic          done,
  input logic [CW-1:0] coef_out,
  input logic [IW-1:0] coef_idx,
  input logic [AW-1:0] mem_addr
);
  assert_excl_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_a && we_b));

  assert_coef_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_a || we_b) |-> (coef_out < CW'(Q)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(we_b && (coef_idx == IW'(2**IW - 1))));

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr == $past(mem_addr)) || (mem_addr == $past(mem_addr) + AW'(1))
    || (mem_addr == '0));
endmodule

bind ct_unpack ct_unpack_chk #(.Q(Q), .CW(CW), .AW(AW), .IW($clog2(N))) u_chk (
  .clk(clk), .rst_n(rst_n), .we_a(we_a), .we_b(we_b), .done(done),
  .coef_out(coef_out), .coef_idx(coef_idx), .mem_addr(mem_addr)
);

// File: tb/ct_unpack_tb_top.sv
module ct_unpack_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] k_in = '0;
  logic [3:0] du_in = '0, dv_in = '0;
  logic [10:0] mem_addr;
  logic [7:0] mem_data;
  logic [11:0] coef_out;
  logic [2:0] poly_idx;
  logic [7:0] coef_idx;
  logic we_a, we_b, done;

  int total = 0;
  int bad = 0;
  logic [7:0] mem [0:2047];

  always #5 clk = ~clk;

  ct_unpack dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .k_in(k_in), .du_in(du_in),
    .dv_in(dv_in), .mem_addr(mem_addr), .mem_data(mem_data),
    .coef_out(coef_out), .poly_idx(poly_idx), .coef_idx(coef_idx),
    .we_a(we_a), .we_b(we_b), .done(done)
  );

  always @(posedge clk) mem_data <= mem[mem_addr];

  // {K, du, dv, expected bytes consumed}
  localparam int VEC [5][4] = '{
    '{2, 10, 4, 768},
    '{3, 10, 4, 1088},
    '{4, 11, 5, 1568},
    '{2, 12, 1, 800},
    '{3, 3, 7, 512}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int getbits(input int pos, input int d);
    int y = 0;
    for (int i = 0; i < d; i++)
      y |= ((mem[(pos + i) / 8] >> ((pos + i) % 8)) & 1) << i;
    return y;
  endfunction

  task automatic run_job(input int k, input int du, input int dv, input int nbytes,
                         input bit disturb);
    int pos = 0;
    int nwr = 0;
    bit early_done = 0;
    @(negedge clk);
    k_in = 3'(k); du_in = 4'(du); dv_in = 4'(dv); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int p = 0; p <= k; p++) begin
      for (int c = 0; c < 256; c++) begin
        int d = (p < k) ? du : dv;
        int y = getbits(pos, d);
        int e = (3329 * y + (1 << (d - 1))) >> d;
        int wait_n = 0;
        pos += d;
        while (!(we_a || we_b) && wait_n < 100) begin
          if (done) early_done = 1;
          @(negedge clk);
          wait_n++;
        end
        if (!(we_a || we_b)) begin
          chk(0, "R4 write missing", nwr, k * 256 + 256);
          return;
        end
        chk(int'(coef_out) == e, (p < k) ? "R3 R2 du coef" : "R3 R5 dv coef", coef_out, e);
        chk(we_a == (p < k) && we_b == (p == k), "R4 R5 strobe", {we_a, we_b}, (p < k) ? 2 : 1);
        chk(int'(poly_idx) == ((p < k) ? p : 0), "R4 R5 poly_idx", poly_idx, (p < k) ? p : 0);
        chk(int'(coef_idx) == c, "R4 coef_idx", coef_idx, c);
        nwr++;
        if (disturb && nwr == 60) begin
          k_in = 3'd4; du_in = 4'd11; dv_in = 4'd5; start = 1'b1;
          @(negedge clk);
          start = 1'b0;
          chk(!done, "R8 done while busy", done, 0);
        end else begin
          @(negedge clk);
        end
      end
    end
    chk(!early_done, "R7 early done", early_done, 0);
    chk(done == 1'b1, "R7 done after last write", done, 1);
    chk(int'(mem_addr) == nbytes, "R6 bytes consumed", mem_addr, nbytes);
    @(negedge clk);
    chk(done == 1'b0, "R7 done width", done, 0);
  endtask

  initial begin
    int seed = 32'h1234_5678;
    for (int i = 0; i < 2048; i++) begin
      seed = seed * 1103515245 + 12345;
      mem[i] = 8'(seed >> 16);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !we_a && !we_b && mem_addr == 0, "R1 reset in", {done, we_a, we_b}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !we_a && !we_b && mem_addr == 0, "R1 after reset", mem_addr, 0);
    for (int v = 0; v < 5; v++)
      run_job(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 1'b0);
    run_job(2, 10, 4, 768, 1'b1);
    repeat (5) @(negedge clk);
    chk(!done && !we_a && !we_b, "R8 idle after ignored start", {done, we_a, we_b}, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule